// File: doc/BRIEF.md
# Gated Frequency Measurement Counter

This block measures the frequency of an external pulse train by counting its edges inside a window. Counting runs only while a window gate is high. The gate comes from one of two sources. One is a gate input pin. The other is an internal generator whose high and low phases are set in prescaled ticks. When the gate closes, software reads the held count and the sticky overflow flag, then decides whether to clear them with a one-cycle strobe. If it does not clear them, the next window continues from the held value.

The block has two counting modes, and they differ in how the closing edge of the gate is treated. In the gate-close mode, rising input edges are counted while the gate is high, and the falling edge of the gate adds one more count. In the AND mode, the counter counts falling edges of the input ANDed with the gate. A one-clock interrupt pulse marks the gate's falling edge, or both of its edges, as configured. The current gate level is available on a status output.

Top module: `gated_freq_counter`

## Requirements
- R1: The count is CNT_W bits wide (default 18) and increments by one per counting event. It wraps from all ones to zero.
- R2: The overflow flag goes to 1 on the cycle the count wraps. It then stays at 1 until the clear strobe is applied.
- R3: Both pins pass through SYNC_STAGES flip-flops before edge detection. No counting event occurs while the selected gate has been low for the current and the previous cycle, so input edges during a closed window leave the count unchanged.
- R4: gate_sel = 2'b00 selects the gate pin. Any other value selects the internal generator, and the gate pin is then ignored.
- R5: With count_mode = 1 (gate-close mode), each rising input edge seen while the gate is high adds one. Each falling edge of the gate also adds one, whatever the input level is.
- R6: With count_mode = 0 (AND mode), each falling edge of (input AND gate) adds one. A gate that falls while the input is high therefore adds one.
- R7: The count is never cleared between windows. Each window adds to the value held from the previous window.
- R8: irq is a one-clock pulse. It fires on every falling gate edge, and also on every rising gate edge when irq_both = 1.
- R9: gate_level shows the selected, synchronized gate.
- R10: The clear strobe sets the count and the overflow flag to zero. It takes priority over an increment or a wrap in the same cycle.
- R11: With gen_run = 1, the internal gate goes high one cycle after gen_run rises. It then alternates a high phase of (gate_hi_len+1)·T cycles and a low phase of (gate_lo_len+1)·T cycles, where T = 2^(PRE_LOG2+gate_sel−1). With gen_run = 0, the internal gate is held low.
- R12: Each phase length is sampled when that phase begins. A length change during a phase takes effect from the next phase of that kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pulse_in | input | 1 | External pulse to be counted (asynchronous) |
| gate_pin | input | 1 | External window gate (asynchronous) |
| gate_sel | input | 2 | 00 = gate pin; 01/10/11 = internal generator at T = 2^(PRE_LOG2+0/1/2) |
| gen_run | input | 1 | Runs the internal gate generator |
| gate_hi_len | input | LEN_W | Internal high phase length minus one, in ticks |
| gate_lo_len | input | LEN_W | Internal low phase length minus one, in ticks |
| count_mode | input | 1 | 1 = gate-close mode, 0 = AND mode |
| irq_both | input | 1 | 1 = interrupt on both gate edges, 0 = falling edge only |
| clr | input | 1 | Clear strobe for the count and the overflow flag |
| count | output | CNT_W | Accumulated count |
| ovf | output | 1 | Sticky overflow flag |
| gate_level | output | 1 | Current selected gate level |
| irq | output | 1 | One-clock interrupt pulse |

## Verification
The clear strobe can land in the same cycle as a counting increment, and that increment can itself be a wrap. The bench provokes both collisions. It raises clr exactly two clocks after driving a pin change, which is the cycle in which the synchronized edge produces an increment. The first case uses a gate close in gate-close mode. The second uses an input rising edge while the count sits at all ones. Each collision is judged correct when the count and the overflow flag read zero afterwards, and the gate-close interrupt still arrives.

// File: rtl/freqm_pkg.sv
// Shared types and constants for the gated frequency measurement counter.
// Assumes nothing beyond standard SystemVerilog packages.
package freqm_pkg;

    typedef enum logic {
        CM_AND_FALL   = 1'b0,
        CM_GATE_CLOSE = 1'b1
    } cnt_mode_e;

    localparam logic [1:0] GSEL_PIN = 2'b00;

endpackage

// File: rtl/freqm_sync.sv
// Multi-stage synchronizer for a vector of asynchronous single-bit inputs.
// Assumes each bit is independent; no bus coherency is implied.
module freqm_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First stage samples the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= d;
            end
        end else begin : g_next
            // Later stages resolve metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[i] <= '0;
                else        stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/freqm_gate_gen.sv
// Internal window gate generator. Gives alternating high and low phases,
// each measured in prescaled ticks. Each phase length is sampled when the
// phase begins. The gate starts high one cycle after run rises. Assumes sel
// is held steady while running; sel = 0 is treated like sel = 1.
module freqm_gate_gen #(
    parameter int LEN_W    = 4,
    parameter int PRE_LOG2 = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       sel,
    input  logic [LEN_W-1:0] hi_len,
    input  logic [LEN_W-1:0] lo_len,
    output logic             gate
);

    localparam int PW = PRE_LOG2 + 3;

    logic [PW-1:0]    pre_cnt;
    logic [PW-1:0]    pre_last;
    logic [LEN_W-1:0] remain;
    logic             started;
    logic             gate_q;
    logic             tick;
    logic [1:0]       sel_eff;

    // Tick period selection from the gate select code.
    always_comb begin
        sel_eff  = (sel == 2'b00) ? 2'b01 : sel;
        pre_last = (PW'(1) << (PRE_LOG2 + int'(sel_eff) - 1)) - PW'(1);
        tick     = (pre_cnt == pre_last);
    end

    // Prescaler, phase counter and gate state.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_cnt <= '0;
            remain  <= '0;
            started <= 1'b0;
            gate_q  <= 1'b0;
        end else if (!started) begin
            started <= 1'b1;
            gate_q  <= 1'b1;
            remain  <= hi_len;
            pre_cnt <= '0;
        end else begin
            pre_cnt <= tick ? '0 : pre_cnt + PW'(1);
            if (tick) begin
                if (remain == '0) begin
                    gate_q <= ~gate_q;
                    remain <= gate_q ? lo_len : hi_len;
                end else begin
                    remain <= remain - LEN_W'(1);
                end
            end
        end
    end

    assign gate = gate_q;

endmodule

// File: rtl/freqm_count_core.sv
// Accumulating up counter with a sticky overflow flag. Clear has priority
// over the increment. Assumes inc is a single-cycle event per counted edge.
module freqm_count_core #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic wrap;

    assign wrap = inc && (count == CNT_MAX);

    // Count register; clear first, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) count <= '0;
        else if (inc)      count <= count + CNT_W'(1);
    end

    // Sticky overflow flag; set on wrap, released only by clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) ovf <= 1'b0;
        else if (wrap)     ovf <= 1'b1;
    end

endmodule

// File: rtl/gated_freq_counter.sv
// Gated frequency measurement counter top. It synchronizes the pulse and
// gate pins, picks the window gate, detects edges, forms the counting event
// for the chosen mode, and registers a one-clock interrupt on gate edges.
// Assumes the pins are asynchronous and slower than the clock.
module gated_freq_counter
    import freqm_pkg::*;
#(
    parameter int CNT_W       = 18,
    parameter int LEN_W       = 4,
    parameter int PRE_LOG2    = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_in,
    input  logic             gate_pin,
    input  logic [1:0]       gate_sel,
    input  logic             gen_run,
    input  logic [LEN_W-1:0] gate_hi_len,
    input  logic [LEN_W-1:0] gate_lo_len,
    input  logic             count_mode,
    input  logic             irq_both,
    input  logic             clr,
    output logic [CNT_W-1:0] count,
    output logic             ovf,
    output logic             gate_level,
    output logic             irq
);

    logic [1:0] sync_q;
    logic       pulse_s;
    logic       pin_s;
    logic       gen_gate;
    logic       gate_now;
    logic       gate_prev;
    logic       pulse_prev;
    logic       and_prev;
    logic       and_now;
    logic       pulse_rise;
    logic       gate_rise;
    logic       gate_fall;
    logic       and_fall;
    logic       inc;
    logic       irq_q;
    cnt_mode_e  mode;

    freqm_sync #(.W(2), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({gate_pin, pulse_in}),
        .q     (sync_q)
    );

    assign pin_s   = sync_q[1];
    assign pulse_s = sync_q[0];

    freqm_gate_gen #(.LEN_W(LEN_W), .PRE_LOG2(PRE_LOG2)) i_gate_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (gen_run),
        .sel    (gate_sel),
        .hi_len (gate_hi_len),
        .lo_len (gate_lo_len),
        .gate   (gen_gate)
    );

    // Window gate source selection.
    assign gate_now = (gate_sel == GSEL_PIN) ? pin_s : gen_gate;

    // Previous-cycle copies for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_prev  <= 1'b0;
            pulse_prev <= 1'b0;
            and_prev   <= 1'b0;
        end else begin
            gate_prev  <= gate_now;
            pulse_prev <= pulse_s;
            and_prev   <= and_now;
        end
    end

    // Edge detection and mode-dependent counting event.
    always_comb begin
        mode       = cnt_mode_e'(count_mode);
        and_now    = pulse_s & gate_now;
        pulse_rise = pulse_s & ~pulse_prev;
        gate_rise  = gate_now & ~gate_prev;
        gate_fall  = gate_prev & ~gate_now;
        and_fall   = and_prev & ~and_now;
        if (mode == CM_GATE_CLOSE) inc = (gate_now & pulse_rise) | gate_fall;
        else                       inc = and_fall;
    end

    // Interrupt pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= gate_fall | (irq_both & gate_rise);
    end

    freqm_count_core #(.CNT_W(CNT_W)) i_core (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (inc),
        .count (count),
        .ovf   (ovf)
    );

    assign gate_level = gate_now;
    assign irq        = irq_q;

endmodule

// File: rtl/freqm_checker.sv
// Property checker for gated_freq_counter, attached by bind. It observes
// only the top-level ports and assumes the top's parameter values.
module freqm_checker #(
    parameter int CNT_W = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic [CNT_W-1:0] count,
    input logic             ovf,
    input logic             gate_level,
    input logic             irq
);

    logic [CNT_W-1:0] cnt_plus;
    assign cnt_plus = count + CNT_W'(1);

    // R1: the count holds or steps by exactly one when no clear is applied.
    a_r1_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (count == $past(count) || count == $past(cnt_plus)));

    // R2: the flag rises only on a wrap from all ones to zero.
    a_r2_ovf_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> ($past(count) == {CNT_W{1'b1}} && count == '0));

    // R2: the flag stays set until cleared.
    a_r2_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf);

    // R10: a clear wins over everything in the same cycle.
    a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0 && !ovf));

    // R3: no count change after two cycles with the gate low.
    a_r3_closed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(clr) && !$past(gate_level) && !$past(gate_level, 2)) |-> $stable(count));

    // R8: an interrupt follows a gate change one cycle earlier.
    a_r8_irq_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(gate_level) != $past(gate_level, 2)));

endmodule

bind gated_freq_counter freqm_checker #(.CNT_W(CNT_W)) i_freqm_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .count      (count),
    .ovf        (ovf),
    .gate_level (gate_level),
    .irq        (irq)
);

// File: tb/test_gated_freq_counter.sv
// Self-checking bench for gated_freq_counter with an 8-bit count.
module test_gated_freq_counter;

    localparam int BW    = 8;
    localparam int LW    = 4;
    localparam int PL    = 1;
    localparam int MODV  = 1 << BW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pulse_in = 1'b0;
    logic          gate_pin = 1'b0;
    logic [1:0]    gate_sel = 2'b00;
    logic          gen_run = 1'b0;
    logic [LW-1:0] gate_hi_len = '0;
    logic [LW-1:0] gate_lo_len = '0;
    logic          count_mode = 1'b1;
    logic          irq_both = 1'b0;
    logic          clr = 1'b0;
    logic [BW-1:0] count;
    logic          ovf;
    logic          gate_level;
    logic          irq;

    int checks = 0;
    int errors = 0;
    int irq_seen = 0;
    int irq_long = 0;
    logic irq_last = 1'b0;
    int exp_cnt = 0;

    always #10 clk = ~clk;

    gated_freq_counter #(.CNT_W(BW), .LEN_W(LW), .PRE_LOG2(PL), .SYNC_STAGES(2)) i_gated_freq_counter (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .gate_pin(gate_pin),
        .gate_sel(gate_sel), .gen_run(gen_run), .gate_hi_len(gate_hi_len),
        .gate_lo_len(gate_lo_len), .count_mode(count_mode), .irq_both(irq_both),
        .clr(clr), .count(count), .ovf(ovf), .gate_level(gate_level), .irq(irq)
    );

    // Interrupt monitor: counts pulses and any pulse longer than one clock.
    always @(negedge clk) begin
        if (irq) irq_seen++;
        if (irq && irq_last) irq_long++;
        irq_last <= irq;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_once();
        pulse_in = 1'b1; tick(4);
        pulse_in = 1'b0; tick(4);
    endtask

    // One pin-gated window with n full pulses; e leaves the input high at close.
    task automatic window(input int n, input int e);
        gate_pin = 1'b1; tick(5);
        check("R9", "gate_level open", int'(gate_level), 1);
        repeat (n) pulse_once();
        if (e != 0) begin pulse_in = 1'b1; tick(4); end
        gate_pin = 1'b0; tick(5);
        check("R9", "gate_level closed", int'(gate_level), 0);
        pulse_in = 1'b0; tick(4);
    endtask

    task automatic wait_level(input logic lvl);
        while (gate_level != lvl) @(negedge clk);
    endtask

    task automatic phase_len(input logic lvl, output int n);
        n = 0;
        while (gate_level == lvl) begin n++; @(negedge clk); end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int base;
        int len;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        check("R1", "reset count", int'(count), 0);
        check("R2", "reset ovf", int'(ovf), 0);
        check("R8", "reset irq", int'(irq), 0);
        check("R9", "reset gate_level", int'(gate_level), 0);

        // R5 / R6 / R7: sweep of both modes, pulse counts and close levels.
        base = irq_seen;
        for (int m = 0; m < 2; m++)
            for (int n = 0; n < 5; n++)
                for (int e = 0; e < 2; e++) begin
                    count_mode = m[0];
                    window(n, e);
                    exp_cnt = (exp_cnt + n + e + m) % MODV;
                    check((m == 1) ? "R5" : "R6", "window accumulate R7", int'(count), exp_cnt);
                end
        check("R8", "falling-only irq count", irq_seen - base, 20);

        // R3: input edges with the gate closed are ignored in both modes.
        for (int m = 0; m < 2; m++) begin
            count_mode = m[0];
            repeat (5) pulse_once();
            check("R3", "closed-window toggles", int'(count), exp_cnt);
        end

        // R8: both-edge interrupts.
        irq_both = 1'b1; count_mode = 1'b1;
        base = irq_seen;
        window(0, 0);
        exp_cnt = (exp_cnt + 1) % MODV;
        check("R8", "both-edge irq count", irq_seen - base, 2);
        irq_both = 1'b0;

        // R1 / R2 / R10: overflow in gate-close mode.
        clr = 1'b1; tick(1); clr = 1'b0; tick(1);
        check("R10", "plain clear", int'(count), 0);
        gate_pin = 1'b1; tick(5);
        repeat (MODV - 1) pulse_once();
        check("R1", "count at max", int'(count), MODV - 1);
        check("R2", "no ovf before wrap", int'(ovf), 0);
        pulse_once();
        check("R1", "wrap to zero", int'(count), 0);
        check("R2", "ovf set on wrap", int'(ovf), 1);
        repeat (3) pulse_once();
        check("R2", "ovf sticky", int'(ovf), 1);
        clr = 1'b1; tick(1); clr = 1'b0; tick(1);
        check("R10", "clear count", int'(count), 0);
        check("R10", "clear ovf", int'(ovf), 0);
        repeat (MODV - 1) pulse_once();
        // R10: clear lands in the cycle of the wrapping increment.
        pulse_in = 1'b1; tick(2); clr = 1'b1; tick(1); clr = 1'b0; tick(3);
        pulse_in = 1'b0; tick(4);
        check("R10", "clear vs wrap count", int'(count), 0);
        check("R10", "clear vs wrap ovf", int'(ovf), 0);
        gate_pin = 1'b0; tick(5);
        pulse_in = 1'b0; tick(2);

        // R10: clear lands in the cycle of the gate-close increment.
        clr = 1'b1; tick(1); clr = 1'b0;
        gate_pin = 1'b1; tick(5);
        pulse_once(); pulse_once();
        check("R5", "pre-close count", int'(count), 2);
        base = irq_seen;
        gate_pin = 1'b0; tick(2); clr = 1'b1; tick(1); clr = 1'b0; tick(4);
        check("R10", "clear vs gate-close inc", int'(count), 0);
        check("R8", "irq still on close", irq_seen - base, 1);

        // R4: pin ignored when the internal source is selected and idle.
        gate_sel = 2'b01; gen_run = 1'b0;
        for (int k = 0; k < 3; k++) begin
            gate_pin = 1'b1; tick(5);
            check("R4", "pin ignored gate_level", int'(gate_level), 0);
            pulse_once();
            gate_pin = 1'b0; tick(5);
        end
        check("R4", "pin ignored count", int'(count), 0);

        // R11 / R12: internal generator phase lengths, T = 2.
        gate_hi_len = 4'd2; gate_lo_len = 4'd1;
        gen_run = 1'b1;
        wait_level(1'b1);
        phase_len(1'b1, len);
        check("R11", "high phase sel01", len, 6);
        gate_lo_len = 4'd3;
        phase_len(1'b0, len);
        check("R12", "low phase keeps old length", len, 4);
        phase_len(1'b1, len);
        check("R11", "second high phase", len, 6);
        phase_len(1'b0, len);
        check("R12", "low phase uses new length", len, 8);
        wait_level(1'b0);
        gen_run = 1'b0; tick(2);
        check("R11", "gate low when stopped", int'(gate_level), 0);

        // R11: doubled tick period with sel 10.
        gate_sel = 2'b10; gate_lo_len = 4'd1;
        gen_run = 1'b1;
        wait_level(1'b1);
        phase_len(1'b1, len);
        check("R11", "high phase sel10", len, 12);
        gen_run = 1'b0; tick(2);

        // R6: AND mode on an internal window with the input held high.
        gate_sel = 2'b01; count_mode = 1'b0;
        pulse_in = 1'b1; tick(4);
        clr = 1'b1; tick(1); clr = 1'b0;
        gen_run = 1'b1;
        wait_level(1'b1);
        wait_level(1'b0);
        tick(3);
        check("R6", "constant-high input count", int'(count), 1);
        gen_run = 1'b0; pulse_in = 1'b0; tick(4);

        check("R8", "irq one clock wide", irq_long, 0);
        finish_run();
    end

endmodule